// File: doc/BRIEF.md
# Video Blanking Inserter with Sync-Word Protection

This block sits on a 10-bit multiplexed 4:2:2 video word stream, one word per pixel clock, and crops the picture by overwriting words with blanking levels while an active-low strobe is held low. The strobe is sampled with each word, so the cropped region follows the strobe's timing word by word. Active picture and ancillary data are overwritten alike. The four words of every timing reference sequence (all-ones, zero, zero, then the XYZ status word) are found in the stream and always leave the block untouched.

The replacement level depends on the sample position. Chroma positions get mid-scale (0x200) and luma positions get black (0x040). The position is counted afresh from the word that follows each XYZ word. Processing is active only when the mode input selects the SMPTE setting. In every other setting the stream is forwarded unchanged. The output lags the input by a fixed five clocks in all modes. The look-ahead needed to recognise a sequence before its first word leaves the block sets this delay.

Top module: `video_blank_inserter`

## Requirements
- R1: With modeSel = 2'b10 and blankN low when a word is accepted, that word leaves the block as a blanking level, unless R3 protects it.
- R2: A word accepted with blankN high leaves the block unchanged.
- R3: Any input run 0x3FF, 0x000, 0x000, W is a sync sequence, whatever the mode. All four of its words, including W, leave unchanged whatever the state of blankN. A run 0x3FF, 0x3FF, 0x000, 0x000, W protects only the last four words.
- R4: The blanking level is 0x200 on chroma positions and 0x040 on luma positions. Positions alternate word by word starting with chroma. Every word counts, including protected and forwarded ones. The word after each sync sequence's last word is chroma.
- R5: With modeSel equal to 2'b00 (data-through), 2'b01 (bypass) or 2'b11 (reserved), every word leaves unchanged.
- R6: blankN is sampled with each word on the rising clock edge, so blanking starts and stops on the exact word where blankN changes.
- R7: Ancillary words, including the header 0x000, 0x3FF, 0x3FF, are blanked like picture words.
- R8: A word applied before rising edge n appears on vidOut after rising edge n+4, in every mode and with blanking on or off.
- R9: rstN low forces vidOut to 0 at once and clears the pipeline. The first word accepted after reset takes the chroma position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vidIn | input | 10 | Incoming video word |
| blankN | input | 1 | Blank strobe for the word on vidIn, active low |
| modeSel | input | 2 | 2'b10 enables blanking; other values forward the stream |
| vidOut | output | 10 | Outgoing video word, five clocks behind vidIn |

## Verification
The bench drives a vector table that mixes several kinds of input. A blanked run straight after a sync sequence shows whether the chroma/luma phase restarts. A sync sequence under a high strobe shows whether pass-through and protection agree. An ancillary header under a low strobe shows that its all-ones words are not taken as sync. Bypass, data-through and reserved segments show that blanking is gated by mode. A run with blankN toggling every word shows per-word strobe timing. A doubled all-ones word in front of a sequence shows that only the true four words are protected. Directed steps then check the output during reset, an asynchronous reset in mid-stream, and that the phase restarts at chroma after reset.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  typedef enum logic [1:0] {
    MODE_THRU   = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_SMPTE  = 2'b10,
    MODE_RSVD   = 2'b11
  } vbiMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic blankNow;   // replace the word leaving the pipeline
    logic chromaNow;  // that word sits on a chroma position
  } vbiStrobe_t;

  // sync sequence length sets the look-ahead depth
  localparam int TRS_LEN = 4;

endpackage

// File: rtl/vbi_ctrl.sv
module vbi_ctrl
  import vbi_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int DEPTH = TRS_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blankN,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] tap0,
  input  logic [WIDTH-1:0] tap1,
  input  logic [WIDTH-1:0] tap2,
  output vbiStrobe_t       strobe
);

  localparam logic [WIDTH-1:0] SYNC_ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] SYNC_ZEROS = '0;

  logic             trsHit;
  logic             wantBlank;
  logic [DEPTH-1:0] protQ;
  logic [DEPTH-1:0] xyzQ;
  logic [DEPTH-1:0] enQ;
  logic [DEPTH-1:0] validQ;
  logic             phaseQ;

  // the three newest stored words open a sequence; the incoming word is XYZ
  assign trsHit = (tap2 == SYNC_ONES) && (tap1 == SYNC_ZEROS) && (tap0 == SYNC_ZEROS);
  assign wantBlank = (modeSel == MODE_SMPTE) && !blankN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protQ  <= '0;
      xyzQ   <= '0;
      enQ    <= '0;
      validQ <= '0;
      phaseQ <= 1'b1;
    end else begin
      protQ  <= {protQ[DEPTH-2:0], 1'b0} | {DEPTH{trsHit}};
      xyzQ   <= {xyzQ[DEPTH-2:0], trsHit};
      enQ    <= {enQ[DEPTH-2:0], wantBlank};
      validQ <= {validQ[DEPTH-2:0], 1'b1};
      if (validQ[DEPTH-1]) begin
        phaseQ <= xyzQ[DEPTH-1] ? 1'b1 : ~phaseQ;
      end
    end
  end

  assign strobe.blankNow  = enQ[DEPTH-1] && !protQ[DEPTH-1];
  assign strobe.chromaNow = phaseQ;

endmodule

// File: rtl/vbi_datapath.sv
module vbi_datapath
  import vbi_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int DEPTH = TRS_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] vidIn,
  input  vbiStrobe_t       strobe,
  output logic [WIDTH-1:0] tap0,
  output logic [WIDTH-1:0] tap1,
  output logic [WIDTH-1:0] tap2,
  output logic [WIDTH-1:0] vidOut
);

  localparam logic [WIDTH-1:0] LEVEL_CHROMA = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH-1:0] LEVEL_LUMA   = WIDTH'(1) << (WIDTH - 4);

  logic [DEPTH-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe   <= '0;
      vidOut <= '0;
    end else begin
      pipe   <= {pipe[DEPTH-2:0], vidIn};
      vidOut <= strobe.blankNow ? (strobe.chromaNow ? LEVEL_CHROMA : LEVEL_LUMA)
                                : pipe[DEPTH-1];
    end
  end

  assign tap0 = pipe[0];
  assign tap1 = pipe[1];
  assign tap2 = pipe[2];

endmodule

// File: rtl/video_blank_inserter.sv
module video_blank_inserter
  import vbi_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] vidIn,
  input  logic             blankN,
  input  logic [1:0]       modeSel,
  output logic [WIDTH-1:0] vidOut
);

  vbiStrobe_t       strobe;
  logic [WIDTH-1:0] tap0, tap1, tap2;

  vbi_ctrl #(.WIDTH(WIDTH), .DEPTH(TRS_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .blankN(blankN), .modeSel(modeSel),
    .tap0(tap0), .tap1(tap1), .tap2(tap2), .strobe(strobe)
  );

  vbi_datapath #(.WIDTH(WIDTH), .DEPTH(TRS_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .vidIn(vidIn), .strobe(strobe),
    .tap0(tap0), .tap1(tap1), .tap2(tap2), .vidOut(vidOut)
  );

endmodule

// File: rtl/vbi_checker.sv
module vbi_checker #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] vidIn,
  input logic             blankN,
  input logic [1:0]       modeSel,
  input logic [WIDTH-1:0] vidOut
);

  localparam logic [WIDTH-1:0] ONES   = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CHROMA = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH-1:0] LUMA   = WIDTH'(1) << (WIDTH - 4);

  logic [3:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != 4'hF) edgeCnt <= edgeCnt + 4'd1;
  end

  AST_BLANK_HIGH_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 4'd5 && $past(blankN, 5)) |-> vidOut == $past(vidIn, 5)); // R2

  AST_MODE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 4'd5 && $past(modeSel, 5) != 2'b10) |-> vidOut == $past(vidIn, 5)); // R5

  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 4'd5 && vidOut != $past(vidIn, 5)) |-> (vidOut == CHROMA || vidOut == LUMA)); // R4

  AST_TRS_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 4'd5 && $past(vidIn, 5) == ONES && $past(vidIn, 4) == '0 && $past(vidIn, 3) == '0)
      |-> vidOut == ONES); // R3

  AST_TRS_XYZ_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 4'd8 && $past(vidIn, 8) == ONES && $past(vidIn, 7) == '0 && $past(vidIn, 6) == '0)
      |-> vidOut == $past(vidIn, 5)); // R3

endmodule

bind video_blank_inserter vbi_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .vidIn(vidIn), .blankN(blankN),
  .modeSel(modeSel), .vidOut(vidOut)
);

// File: tb/video_blank_inserter_tb.sv
`timescale 1ns/1ps
module video_blank_inserter_tb;

  typedef struct packed {
    logic [9:0] word;
    logic       bN;
    logic [1:0] mode;
  } vec_t;

  localparam int NV  = 37;
  localparam int LAT = 5;

  // stimulus table; expected outputs are derived below from the requirements
  localparam vec_t VECS [NV] = '{
    '{10'h3FF, 1'b0, 2'b10}, '{10'h000, 1'b0, 2'b10}, '{10'h000, 1'b0, 2'b10}, '{10'h274, 1'b0, 2'b10}, // R3 under blank
    '{10'h123, 1'b0, 2'b10}, '{10'h234, 1'b0, 2'b10}, '{10'h345, 1'b0, 2'b10}, '{10'h156, 1'b0, 2'b10}, // R1 R4
    '{10'h0AA, 1'b1, 2'b10}, '{10'h155, 1'b1, 2'b10}, '{10'h2AA, 1'b1, 2'b10}, '{10'h3FE, 1'b1, 2'b10}, // R2
    '{10'h3FF, 1'b1, 2'b10}, '{10'h000, 1'b1, 2'b10}, '{10'h000, 1'b1, 2'b10}, '{10'h2D8, 1'b1, 2'b10}, // R2 R3
    '{10'h000, 1'b0, 2'b10}, '{10'h3FF, 1'b0, 2'b10}, '{10'h3FF, 1'b0, 2'b10}, '{10'h1C3, 1'b0, 2'b10}, // R7
    '{10'h111, 1'b0, 2'b01}, '{10'h222, 1'b0, 2'b01}, '{10'h333, 1'b0, 2'b11}, '{10'h0F0, 1'b0, 2'b11}, // R5
    '{10'h3FF, 1'b0, 2'b00}, '{10'h000, 1'b0, 2'b00}, '{10'h000, 1'b0, 2'b00}, '{10'h3C4, 1'b0, 2'b00}, // R5 R3
    '{10'h050, 1'b0, 2'b10}, '{10'h060, 1'b1, 2'b10}, '{10'h070, 1'b0, 2'b10}, '{10'h080, 1'b1, 2'b10}, // R6
    '{10'h3FF, 1'b0, 2'b10}, '{10'h3FF, 1'b0, 2'b10}, '{10'h000, 1'b0, 2'b10}, '{10'h000, 1'b0, 2'b10},
    '{10'h2AC, 1'b0, 2'b10}                                                                             // R3 doubled ones
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] vidIn = '0;
  logic       blankN = 1'b1;
  logic [1:0] modeSel = 2'b10;
  logic [9:0] vidOut;

  int checks = 0;
  int errors = 0;
  logic [9:0] expOut [NV];
  string      expTag [NV];

  always #2.5 clk = ~clk;

  video_blank_inserter u_dut (
    .clk(clk), .rstN(rstN), .vidIn(vidIn), .blankN(blankN),
    .modeSel(modeSel), .vidOut(vidOut)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] w, input logic b, input logic [1:0] m);
    vidIn = w; blankN = b; modeSel = m;
  endtask

  // reference model built from R1-style rules, independent of the RTL
  initial begin
    logic prot [NV];
    logic xyz  [NV];
    logic ph;
    for (int i = 0; i < NV; i++) begin prot[i] = 1'b0; xyz[i] = 1'b0; end
    for (int k = 0; k + 3 < NV; k++) begin
      if (VECS[k].word == 10'h3FF && VECS[k+1].word == 10'h000 && VECS[k+2].word == 10'h000) begin
        for (int m = 0; m < 4; m++) prot[k+m] = 1'b1;
        xyz[k+3] = 1'b1;
      end
    end
    ph = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mode == 2'b10 && !VECS[i].bN && !prot[i]) begin
        expOut[i] = ph ? 10'h200 : 10'h040;
        expTag[i] = "R1 R4 R6 R7 R8";
      end else begin
        expOut[i] = VECS[i].word;
        expTag[i] = prot[i] ? "R3 R8" : (VECS[i].mode != 2'b10 ? "R5 R8" : "R2 R6 R8");
      end
      ph = xyz[i] ? 1'b1 : ~ph;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 output during reset", vidOut, 10'h000);

    // table walk: output for word j-5 is sampled before word j is driven
    @(negedge clk);
    rstN = 1'b1;
    for (int j = 0; j < NV + LAT; j++) begin
      if (j >= LAT) check(expTag[j-LAT], vidOut, expOut[j-LAT]);
      if (j < NV) drive(VECS[j].word, VECS[j].bN, VECS[j].mode);
      else        drive(10'h1AB, 1'b1, 2'b10);
      @(negedge clk);
    end

    // R9: asynchronous reset mid-stream
    check("R2 idle pass before reset", vidOut, 10'h1AB);
    #1 rstN = 1'b0;
    #0.5 check("R9 async clear", vidOut, 10'h000);
    @(negedge clk);
    check("R9 held in reset", vidOut, 10'h000);

    // R9 R4: phase restarts at chroma after reset
    rstN = 1'b1;
    for (int j = 0; j < 3 + LAT; j++) begin
      if (j >= LAT) check("R9 R4 phase after reset", vidOut, ((j - LAT) % 2 == 0) ? 10'h200 : 10'h040);
      if (j < 3) drive(10'h155, 1'b0, 2'b10);
      else       drive(10'h155, 1'b1, 2'b10);
      @(negedge clk);
    end
    check("R2 R8 pass resumes", vidOut, 10'h155);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule